// File: doc/BRIEF.md
# Page-mode burst DRAM controller

This block turns read and write requests from a single requester into the strobe and address sequence that a page-mode DRAM expects. Each cell address is split into a row half and a column half, and both halves use one shared address bus. The row half is presented while the row strobe falls, and the column half is presented while the column strobe is low. Once a row has been opened it stays open after the access ends. A later request to the same row therefore goes straight to the column phase. A request to a different row first closes the page for a precharge interval and then opens the new row.

A read may ask for one word or for a burst of four. In a burst the controller steps the two low column bits itself, starting at the requested column and wrapping inside the aligned group of four. Access timing is set by parameters. An access that needs a row phase takes T_FIRST cycles for its first word, and every other word takes T_NEXT cycles, giving patterns such as 5-2-2-2 or 5-1-1-1. Each read word comes back on a registered data port together with a one-cycle valid pulse. A write always moves exactly one word, with the write strobe held low during its column phase.

Top module: `pgdram_ctrl`

## Requirements
- R1: After reset the row, column and write strobes are high (inactive), rd_valid is low, req_ready is high and no page is open.
- R2: req_ready is high only while the controller is idle. A request is taken only in a cycle where req_valid and req_ready are both high, and a request presented while req_ready is low has no effect.
- R3: A read to a closed page (no row open) makes the row strobe fall, and its first word appears on rd_valid exactly T_FIRST cycles after the accepting edge.
- R4: A request whose row differs from the open row first drives the row strobe high for exactly T_PRE cycles, and its first word appears T_PRE+T_FIRST cycles after the accepting edge.
- R5: A request to the open row keeps the row strobe low throughout, and its first word appears T_NEXT cycles after the accepting edge.
- R6: The four words of a burst read arrive as four one-cycle rd_valid pulses spaced T_NEXT cycles apart.
- R7: Within a burst the column bits [1:0] take the values c, c+1, c+2, c+3 modulo 4, where c is the requested value, and the upper column bits stay fixed. The returned data follow that order.
- R8: The request address is {row, column}, with the row in bits [2*HALF-1:HALF] and the column in bits [HALF-1:0]. The row half is on dram_addr when the row strobe falls, and the column half is on dram_addr while the column strobe is low.
- R9: A write (req_write=1) moves one word whatever req_burst holds. The write strobe is low only while the column strobe is low, dram_wdata carries req_wdata, and no rd_valid pulse follows.
- R10: The column strobe is low only while the row strobe is low, and the row strobe stays low in idle after an access so that the page remains open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = single-word write, 0 = read |
| req_burst | input | 1 | 1 = four-word read burst (ignored for writes) |
| req_addr | input | 2*HALF | Word address {row, column} |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle pulse per returned read word |
| rd_data | output | DW | Read word |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_addr | output | HALF | Multiplexed row/column address |
| dram_wdata | output | DW | Data to the DRAM |
| dram_rdata | input | DW | Data from the DRAM, sampled at the end of each word slot |

## Verification
The assertions rely on a few conditions outside the block. HALF is at least 3, T_FIRST exceeds T_NEXT, and the memory drives dram_rdata combinationally from the row latched at the row-strobe fall and the column currently on the bus. The wrap property also assumes that two requests never run their column phases back to back without an idle cycle between them, which the controller's own idle return guarantees. The stimulus meets these conditions by using the default parameters and a memory model that latches the row on the strobe's falling edge. Every request is raised only after req_ready has been seen high at a falling clock edge, apart from one deliberate pulse sent while busy to show that it is ignored.

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl #(
  parameter int HALF    = 5,
  parameter int DW      = 16,
  parameter int T_FIRST = 5,
  parameter int T_NEXT  = 2,
  parameter int T_PRE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [2*HALF-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [HALF-1:0]   dram_addr,
  output logic [DW-1:0]     dram_wdata,
  input  logic [DW-1:0]     dram_rdata
);
  localparam int AW = 2 * HALF;
  localparam int CW = $clog2(T_FIRST + T_PRE + 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ROW, S_COL} state_t;

  state_t          st;
  logic [CW-1:0]   cnt;
  logic [HALF-1:0] row_q, col_q, pg_row;
  logic            pg_open, wr_q;
  logic [1:0]      left;
  logic [DW-1:0]   wdata_q;

  wire [HALF-1:0] req_row = req_addr[AW-1:HALF];
  wire            accept  = req_valid && (st == S_IDLE);

  assign req_ready  = (st == S_IDLE);
  assign dram_ras_n = !((st == S_ROW) || (st == S_COL) || ((st == S_IDLE) && pg_open));
  assign dram_cas_n = (st != S_COL);
  assign dram_we_n  = !((st == S_COL) && wr_q);
  assign dram_addr  = (st == S_ROW) ? row_q : col_q;
  assign dram_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      row_q    <= '0;
      col_q    <= '0;
      pg_row   <= '0;
      pg_open  <= 1'b0;
      wr_q     <= 1'b0;
      left     <= '0;
      wdata_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          row_q   <= req_row;
          col_q   <= req_addr[HALF-1:0];
          wr_q    <= req_write;
          wdata_q <= req_wdata;
          left    <= (req_burst && !req_write) ? 2'd3 : 2'd0;
          if (pg_open && pg_row == req_row) begin
            st  <= S_COL;
            cnt <= CW'(T_NEXT - 1);
          end else if (pg_open) begin
            st      <= S_PRE;
            cnt     <= CW'(T_PRE - 1);
            pg_open <= 1'b0;
          end else begin
            st  <= S_ROW;
            cnt <= CW'(T_FIRST - T_NEXT - 1);
          end
        end
        S_PRE: begin
          if (cnt == '0) begin
            st  <= S_ROW;
            cnt <= CW'(T_FIRST - T_NEXT - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_ROW: begin
          if (cnt == '0) begin
            st      <= S_COL;
            cnt     <= CW'(T_NEXT - 1);
            pg_open <= 1'b1;
            pg_row  <= row_q;
          end else cnt <= cnt - 1'b1;
        end
        S_COL: begin
          if (cnt == '0) begin
            if (!wr_q) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_rdata;
            end
            if (left == 2'd0) st <= S_IDLE;
            else begin
              left       <= left - 2'd1;
              col_q[1:0] <= col_q[1:0] + 2'd1;
              cnt        <= CW'(T_NEXT - 1);
            end
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_cas_in_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  assert_single_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_valid_after_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!dram_cas_n));

  assert_burst_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n) && dram_addr != $past(dram_addr)) |->
      (dram_addr[HALF-1:2] == $past(dram_addr[HALF-1:2]) &&
       dram_addr[1:0] == 2'($past(dram_addr[1:0]) + 2'd1)));

  assert_write_in_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !dram_cas_n);
endmodule

// File: tb/sim_pgdram_ctrl.sv
`timescale 1ns/1ps
module sim_pgdram_ctrl;
  localparam int HALF = 5, DW = 16, T_FIRST = 5, T_NEXT = 2, T_PRE = 2;
  localparam int AW = 2 * HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, dram_ras_n, dram_cas_n, dram_we_n;
  logic [DW-1:0] rd_data, dram_wdata, dram_rdata;
  logic [HALF-1:0] dram_addr;

  always #4 clk = ~clk;

  pgdram_ctrl #(.HALF(HALF), .DW(DW), .T_FIRST(T_FIRST), .T_NEXT(T_NEXT), .T_PRE(T_PRE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata));

  logic [DW-1:0] dmem [0:(1<<AW)-1];
  logic [DW-1:0] refm [0:(1<<AW)-1];
  logic [HALF-1:0] mrow = '0;
  logic ras_q = 1'b1;
  always @(posedge clk) begin
    ras_q <= dram_ras_n;
    if (!dram_ras_n && ras_q) mrow <= dram_addr;
    if (!dram_cas_n && !dram_we_n) dmem[{mrow, dram_addr}] <= dram_wdata;
  end
  assign dram_rdata = dmem[{mrow, dram_addr}];

  int errors = 0, checks = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [DW-1:0] q_data[$];
  longint q_due[$];
  string q_tag[$];
  logic [HALF-1:0] exp_row = '0;
  logic [DW-1:0] exp_wd = '0;
  bit chk_pre = 0, page_open = 0;
  logic [HALF-1:0] prow = '0;
  int ras_falls = 0, hi_cnt = 0, we_cnt = 0;
  bit prev_ras = 1;

  always @(negedge clk) if (rst_n) begin
    if (rd_valid) begin
      if (q_data.size() == 0) chk(0, "R2 unexpected rd_valid", 1, 0);
      else begin
        logic [DW-1:0] d; longint due; string t;
        d = q_data.pop_front(); due = q_due.pop_front(); t = q_tag.pop_front();
        chk(rd_data == d, {t, " data"}, rd_data, d);
        chk(cyc == due, {t, " R6 timing"}, cyc, due);
      end
    end
    if (dram_ras_n) hi_cnt++;
    if (prev_ras && !dram_ras_n) begin
      ras_falls++;
      chk(dram_addr == exp_row, "R8 row half at row strobe fall", dram_addr, exp_row);
      if (chk_pre) chk(hi_cnt == T_PRE, "R4 precharge length", hi_cnt, T_PRE);
      chk_pre = 0;
    end
    if (!dram_ras_n) hi_cnt = 0;
    prev_ras = dram_ras_n;
    if (!dram_we_n) begin
      we_cnt++;
      chk(dram_wdata == exp_wd, "R9 write data", dram_wdata, exp_wd);
    end
  end

  task automatic issue(input bit wr, input bit burst, input logic [HALF-1:0] row,
                       input logic [HALF-1:0] col, input logic [DW-1:0] wd, input string tag);
    longint base, acc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (page_open && prow == row) base = T_NEXT;
    else if (page_open) begin base = T_PRE + T_FIRST; chk_pre = 1; end
    else base = T_FIRST;
    exp_row = row;
    req_valid = 1; req_write = wr; req_burst = burst; req_addr = {row, col}; req_wdata = wd;
    acc = cyc;
    if (!wr) begin
      for (int k = 0; k < (burst ? 4 : 1); k++) begin
        logic [AW-1:0] a;
        a = {row, col[HALF-1:2], 2'(col[1:0] + 2'(k))};
        q_data.push_back(refm[a]);
        q_due.push_back(acc + 1 + base + k * T_NEXT);
        q_tag.push_back(tag);
      end
    end else begin
      refm[{row, col}] = wd;
      exp_wd = wd;
    end
    page_open = 1; prow = row;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready || q_data.size() != 0) @(negedge clk);
  endtask

  bit done = 0;
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int f0, w0;
    for (int a = 0; a < (1 << AW); a++) begin
      dmem[a] = DW'((a * 37) ^ 16'h5a00);
      refm[a] = dmem[a];
    end
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dram_ras_n == 1, "R1 row strobe", dram_ras_n, 1);
    chk(dram_cas_n == 1, "R1 column strobe", dram_cas_n, 1);
    chk(dram_we_n == 1, "R1 write strobe", dram_we_n, 1);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);

    issue(0, 0, 5'd3, 5'd5, '0, "R3 closed page");
    wait_idle();
    chk(ras_falls == 1, "R3 row strobe fell once", ras_falls, 1);

    f0 = ras_falls;
    issue(0, 0, 5'd3, 5'd9, '0, "R5 page hit");
    wait_idle();
    chk(ras_falls == f0, "R5 no new row phase", ras_falls, f0);

    issue(0, 1, 5'd3, 5'd6, '0, "R7 wrapped burst hit");
    wait_idle();

    issue(0, 1, 5'd10, 5'd0, '0, "R4 row change burst");
    wait_idle();
    chk(ras_falls == f0 + 1, "R4 one new row phase", ras_falls, f0 + 1);

    issue(0, 1, 5'd10, 5'd3, '0, "R7 wrap from 3");
    wait_idle();

    f0 = ras_falls;
    issue(0, 1, 5'd10, 5'd8, '0, "R2 burst while poked");
    chk(req_ready == 0, "R2 busy during burst", req_ready, 0);
    req_valid = 1; req_write = 0; req_burst = 0; req_addr = {5'd20, 5'd1};
    repeat (2) @(negedge clk);
    req_valid = 0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk(ras_falls == f0, "R2 ignored request opened no row", ras_falls, f0);

    w0 = we_cnt;
    issue(1, 1, 5'd10, 5'd13, 16'hbeef, "R9 write hit");
    wait_idle();
    chk(we_cnt - w0 == T_NEXT, "R9 write strobe cycles", we_cnt - w0, T_NEXT);
    issue(0, 1, 5'd10, 5'd12, '0, "R9 readback and neighbours");
    wait_idle();

    issue(1, 0, 5'd2, 5'd1, 16'h1234, "R9 write miss");
    wait_idle();
    issue(0, 0, 5'd2, 5'd1, '0, "R9 readback miss");
    wait_idle();

    chk(dram_ras_n == 0, "R10 page kept open", dram_ras_n, 0);
    chk(dram_cas_n == 1, "R10 column strobe idle", dram_cas_n, 1);
    repeat (10) @(negedge clk);
    chk(q_data.size() == 0, "R6 all words returned", q_data.size(), 0);
    finish_run();
  end
endmodule